// File: doc/BRIEF.md
# Seven-to-one multilane link serializer

This block turns a 28-bit parallel word, presented once per pixel clock, into four serial lanes that each carry seven bits per pixel period. A forwarded framing clock goes out next to the lanes so that the far end can find word boundaries. The serial side is modelled digitally. An external bit clock runs at seven times the pixel rate, and the block samples the pixel clock and the parallel word in that bit-clock domain. A select input picks which pixel-clock edge captures the word. A narrow mode sends 21 bits over three lanes and leaves the fourth lane idle.

Every serial output has an enable that a pad ring can use to drive a tristate. The enables are off while the active-low power-down input is low. After power-down is released they stay off for a settle interval, counted in bit clocks, and a ready flag reports the end of that interval. Once the framing clock is running it keeps running even if the pixel clock stops. The lanes then resend the last captured word.

Top module: `pixlink_ser`

## Requirements
- R1: While `rst_n` is low, every lane output, lane enable, `fclk_o`, `fclk_oe` and `ready` is 0. The enable of lane 0 always equals `fclk_oe`.
- R2: With reset released and `pd_n` high, `ready` rises after exactly `SETTLE_CYCLES` rising bit-clock edges. All enables stay 0 until then.
- R3: While `pd_n` is 0, all lane enables, all lane outputs, `fclk_oe` and `fclk_o` are 0 in the same cycle, whatever the other inputs are. `ready` is 0 from the next edge onward. When `pd_n` returns high, the settle interval of R2 starts again.
- R4: While enabled, `fclk_o` repeats a seven-bit frame: 1 for four bit periods, then 0 for three.
- R5: Lane L carries word bits [7L+6:7L], most significant bit first. That bit leaves two bit periods after the rising edge of `fclk_o`.
- R6: Each captured word appears exactly once, in one frame on all lanes, and words come out in capture order.
- R7: With `rise_sel` = 1 the word is captured on the rising edge of `pclk`. With `rise_sel` = 0 it is captured on the falling edge. Data that is present only at the other edge never reaches a lane.
- R8: With `narrow` = 1, lanes 0 to 2 carry word bits 20:0 as in R5. Lane 3 has its enable and its output at 0, so bits 27:21 have no effect.
- R9: If `pclk` holds a steady level while enabled, `fclk_o` keeps its R4 frame and every lane repeats the last captured word in every frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down |
| rise_sel | input | 1 | Capture edge: 1 rising, 0 falling |
| narrow | input | 1 | 1 selects the three-lane, 21-bit mode |
| pclk | input | 1 | Pixel clock, sampled in the bit-clock domain |
| pdata | input | 28 | Parallel pixel word |
| lane_o | output | 4 | Serial lane data, MSB first |
| lane_oe | output | 4 | Per-lane output enable for tristate drivers |
| fclk_o | output | 1 | Forwarded framing clock |
| fclk_oe | output | 1 | Output enable of the framing clock |
| ready | output | 1 | Settle interval complete |

## Verification
The assertions check on every cycle that the framing clock keeps its four-high, three-low shape, that power-down shuts off every output at once, that the idle lane stays off in narrow mode, and that ready rises only after the full settle count. Some behaviour can only be shown by the bench scenarios, because it needs whole words to be rebuilt from the serial stream: the lane and bit mapping, in-order delivery of one word per frame, the choice of capture edge with decoy data placed at the other edge, and repetition of the last word while the pixel clock is stopped.

// File: rtl/pixlink_ser_pkg.sv
package pixlink_ser_pkg;

   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } cap_edge_e;

   // modular step used to place the lane load point inside the frame
   function automatic int wrap_add(input int a, input int b, input int m);
      return (a + b) % m;
   endfunction

endpackage

// File: rtl/pixlink_ser_settle.sv
module pixlink_ser_settle #(
   parameter int SETTLE_CYCLES = 64
) (
   input  logic bclk,
   input  logic rst_n,
   input  logic pd_n,
   output logic ready
);
   localparam int CW = $clog2(SETTLE_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ready <= 1'b0;
      end else if (!pd_n) begin
         cnt_q <= '0;
         ready <= 1'b0;
      end else if (!ready) begin
         if (cnt_q == LAST) begin
            ready <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/pixlink_ser_capture.sv
module pixlink_ser_capture
   import pixlink_ser_pkg::*;
#(
   parameter int WORD_W = 28
) (
   input  logic              bclk,
   input  logic              rst_n,
   input  logic              pclk,
   input  logic              rise_sel,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] word_q
);
   logic      pclk_q;
   logic      hit;
   cap_edge_e sel;

   assign sel = cap_edge_e'(rise_sel);

   always_comb begin
      if (sel == EDGE_RISE) begin
         hit = pclk & ~pclk_q;
      end else begin
         hit = ~pclk & pclk_q;
      end
   end

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         pclk_q <= 1'b0;
         word_q <= '0;
      end else begin
         pclk_q <= pclk;
         if (hit) begin
            word_q <= din;
         end
      end
   end

endmodule

// File: rtl/pixlink_ser_framer.sv
module pixlink_ser_framer
   import pixlink_ser_pkg::*;
#(
   parameter int BITS          = 7,
   parameter int CLK_HIGH_BITS = 4,
   parameter int MSB_DELAY     = 2
) (
   input  logic bclk,
   input  logic rst_n,
   input  logic run,
   output logic load,
   output logic fclk_bit
);
   localparam int PW = $clog2(BITS);
   localparam int LOAD_PH = wrap_add(MSB_DELAY, BITS - 1, BITS);
   localparam logic [PW-1:0] PH_LAST = PW'(BITS - 1);
   localparam logic [PW-1:0] PH_LOAD = PW'(LOAD_PH);
   localparam logic [PW-1:0] PH_HIGH = PW'(CLK_HIGH_BITS);

   logic [PW-1:0] phase_q;

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (!run) begin
         phase_q <= '0;
      end else if (phase_q == PH_LAST) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end

   assign load     = run && (phase_q == PH_LOAD);
   assign fclk_bit = (phase_q < PH_HIGH);

endmodule

// File: rtl/pixlink_ser_lane.sv
module pixlink_ser_lane #(
   parameter int BITS = 7
) (
   input  logic            bclk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [BITS-1:0] par,
   output logic            ser
);
   logic [BITS-1:0] sh_q;

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (load) begin
         sh_q <= par;
      end else begin
         sh_q <= {sh_q[BITS-2:0], 1'b0};
      end
   end

   assign ser = sh_q[BITS-1];

endmodule

// File: rtl/pixlink_ser.sv
module pixlink_ser #(
   parameter int LANES         = 4,
   parameter int BITS          = 7,
   parameter int NARROW_LANES  = 3,
   parameter int SETTLE_CYCLES = 64,
   parameter int CLK_HIGH_BITS = 4,
   parameter int MSB_DELAY     = 2,
   localparam int WORD_W       = LANES * BITS
) (
   input  logic              bclk,
   input  logic              rst_n,
   input  logic              pd_n,
   input  logic              rise_sel,
   input  logic              narrow,
   input  logic              pclk,
   input  logic [WORD_W-1:0] pdata,
   output logic [LANES-1:0]  lane_o,
   output logic [LANES-1:0]  lane_oe,
   output logic              fclk_o,
   output logic              fclk_oe,
   output logic              ready
);
   if (BITS < 2) begin : g_bad_bits
      $error("BITS must be at least 2");
   end
   if (NARROW_LANES < 1 || NARROW_LANES > LANES) begin : g_bad_narrow
      $error("NARROW_LANES must lie in 1..LANES");
   end
   if (CLK_HIGH_BITS < 1 || CLK_HIGH_BITS >= BITS) begin : g_bad_high
      $error("CLK_HIGH_BITS must lie in 1..BITS-1");
   end
   if (MSB_DELAY < 0 || MSB_DELAY >= BITS) begin : g_bad_delay
      $error("MSB_DELAY must lie in 0..BITS-1");
   end
   if (SETTLE_CYCLES < 1) begin : g_bad_settle
      $error("SETTLE_CYCLES must be at least 1");
   end

   logic [WORD_W-1:0] word_q;
   logic              load;
   logic              fclk_bit;
   logic              out_en;
   logic [LANES-1:0]  ser;
   logic [LANES-1:0]  lane_on;

   pixlink_ser_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
      .bclk  (bclk),
      .rst_n (rst_n),
      .pd_n  (pd_n),
      .ready (ready)
   );

   pixlink_ser_capture #(.WORD_W(WORD_W)) u_cap (
      .bclk     (bclk),
      .rst_n    (rst_n),
      .pclk     (pclk),
      .rise_sel (rise_sel),
      .din      (pdata),
      .word_q   (word_q)
   );

   pixlink_ser_framer #(
      .BITS          (BITS),
      .CLK_HIGH_BITS (CLK_HIGH_BITS),
      .MSB_DELAY     (MSB_DELAY)
   ) u_frm (
      .bclk     (bclk),
      .rst_n    (rst_n),
      .run      (ready),
      .load     (load),
      .fclk_bit (fclk_bit)
   );

   // power-down gates the enables without waiting for a clock edge
   assign out_en  = ready & pd_n;
   assign fclk_oe = out_en;
   assign fclk_o  = out_en & fclk_bit;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      pixlink_ser_lane #(.BITS(BITS)) u_lane (
         .bclk  (bclk),
         .rst_n (rst_n),
         .load  (load),
         .par   (word_q[l*BITS +: BITS]),
         .ser   (ser[l])
      );

      if (l < NARROW_LANES) begin : g_core
         assign lane_on[l] = 1'b1;
      end else begin : g_wide
         assign lane_on[l] = ~narrow;
      end

      assign lane_oe[l] = out_en & lane_on[l];
      assign lane_o[l]  = lane_oe[l] & ser[l];
   end

endmodule

// File: rtl/pixlink_ser_chk.sv
module pixlink_ser_chk #(
   parameter int LANES         = 4,
   parameter int BITS          = 7,
   parameter int NARROW_LANES  = 3,
   parameter int SETTLE_CYCLES = 64,
   parameter int CLK_HIGH_BITS = 4
) (
   input logic             bclk,
   input logic             rst_n,
   input logic             pd_n,
   input logic             narrow,
   input logic [LANES-1:0] lane_o,
   input logic [LANES-1:0] lane_oe,
   input logic             fclk_o,
   input logic             fclk_oe,
   input logic             ready
);
   localparam int SW = $clog2(SETTLE_CYCLES + 1);
   localparam int RW = $clog2(BITS + 1);
   localparam logic [SW-1:0] S_END = SW'(SETTLE_CYCLES);
   localparam logic [RW-1:0] R_HI  = RW'(CLK_HIGH_BITS);
   localparam logic [RW-1:0] R_LO  = RW'(BITS - CLK_HIGH_BITS);
   localparam logic [LANES-1:0] IDLE_MASK = ~((LANES'(1) << NARROW_LANES) - LANES'(1));

   logic [SW-1:0] up_cnt;
   logic [RW-1:0] run_len;
   logic          run_lvl;

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         up_cnt <= '0;
      end else if (!pd_n) begin
         up_cnt <= '0;
      end else if (up_cnt != S_END) begin
         up_cnt <= up_cnt + 1'b1;
      end
   end

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         run_len <= '0;
         run_lvl <= 1'b0;
      end else if (!fclk_oe) begin
         run_len <= '0;
      end else if (run_len == '0 || fclk_o != run_lvl) begin
         run_lvl <= fclk_o;
         run_len <= RW'(1);
      end else begin
         run_len <= run_len + 1'b1;
      end
   end

   // R1
   lane0_tracks_clk_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      lane_oe[0] == fclk_oe);

   // R2
   settle_len_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      $rose(ready) |-> up_cnt == S_END);

   // R3
   pd_quiet_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      !pd_n |-> (lane_oe == '0 && lane_o == '0 && !fclk_oe && !fclk_o));

   // R3
   pd_drop_ready_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      !pd_n |=> !ready);

   // R4
   fclk_run_end_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      (fclk_oe && run_len != '0 && fclk_o != run_lvl) |-> run_len == (run_lvl ? R_HI : R_LO));

   // R4
   fclk_run_max_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      (fclk_oe && run_len != '0 && fclk_o == run_lvl) |-> run_len < (run_lvl ? R_HI : R_LO));

   // R8
   narrow_idle_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      narrow |-> ((lane_oe & IDLE_MASK) == '0 && (lane_o & IDLE_MASK) == '0));

endmodule

bind pixlink_ser pixlink_ser_chk #(
   .LANES         (LANES),
   .BITS          (BITS),
   .NARROW_LANES  (NARROW_LANES),
   .SETTLE_CYCLES (SETTLE_CYCLES),
   .CLK_HIGH_BITS (CLK_HIGH_BITS)
) u_chk (
   .bclk    (bclk),
   .rst_n   (rst_n),
   .pd_n    (pd_n),
   .narrow  (narrow),
   .lane_o  (lane_o),
   .lane_oe (lane_oe),
   .fclk_o  (fclk_o),
   .fclk_oe (fclk_oe),
   .ready   (ready)
);

// File: tb/pixlink_ser_test.sv
module pixlink_ser_test;
   localparam int CLK_PERIOD = 10;
   localparam int LANES      = 4;
   localparam int BITS       = 7;
   localparam int SETTLE     = 64;
   localparam int MSB_DELAY  = 2;
   localparam int W          = LANES * BITS;
   localparam int LAST_PH    = (MSB_DELAY + BITS - 1) % BITS;
   localparam logic [W-1:0] MASK21 = 28'h01F_FFFF;

   logic         bclk = 1'b0;
   logic         rst_n = 1'b0;
   logic         pd_n = 1'b1;
   logic         rise_sel = 1'b1;
   logic         narrow = 1'b0;
   logic         pclk = 1'b0;
   logic [W-1:0] pdata = '0;
   logic [LANES-1:0] lane_o, lane_oe;
   logic         fclk_o, fclk_oe, ready;

   pixlink_ser #(.SETTLE_CYCLES(SETTLE), .MSB_DELAY(MSB_DELAY)) uut (
      .bclk(bclk), .rst_n(rst_n), .pd_n(pd_n), .rise_sel(rise_sel),
      .narrow(narrow), .pclk(pclk), .pdata(pdata), .lane_o(lane_o),
      .lane_oe(lane_oe), .fclk_o(fclk_o), .fclk_oe(fclk_oe), .ready(ready)
   );

   always #(CLK_PERIOD/2) bclk = ~bclk;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard state
   logic [W-1:0]    exp_q[$];
   logic [BITS-1:0] sh [LANES];
   logic [W-1:0]    last_w = '0;
   bit armed = 0;
   bit prev_f = 0;
   int ph = 0;
   int nb = 0;
   int matched = 0;
   int narrow_bad = 0;

   task automatic take_frame(input logic [W-1:0] got);
      logic [W-1:0] e;
      if (!armed) begin
         if (exp_q.size() > 0 && got == exp_q[0]) begin
            armed = 1; last_w = exp_q.pop_front(); matched++;
         end else if (exp_q.size() > 1 && got == exp_q[1]) begin
            void'(exp_q.pop_front());
            armed = 1; last_w = exp_q.pop_front(); matched++;
         end
      end else if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         // R5 lane mapping, R6 order
         chk(got == e, "R5 R6 word", 32'(got), 32'(e));
         last_w = e;
         matched++;
      end else begin
         chk(got == last_w, "R9 repeat", 32'(got), 32'(last_w));
      end
   endtask

   // monitor: rebuild words from the serial outputs
   always @(negedge bclk) begin
      logic [W-1:0] got;
      #(CLK_PERIOD/4);
      if (narrow && (lane_oe[3] || lane_o[3])) narrow_bad++;
      if (!fclk_oe) begin
         prev_f = 0;
         nb = 0;
      end else begin
         if (fclk_o && !prev_f) ph = 0;
         else ph = (ph + 1) % BITS;
         prev_f = fclk_o;
         for (int l = 0; l < LANES; l++) sh[l] = {sh[l][BITS-2:0], lane_o[l]};
         nb++;
         if (ph == LAST_PH && nb >= BITS) begin
            for (int l = 0; l < LANES; l++) got[l*BITS +: BITS] = sh[l];
            take_frame(got);
         end
      end
   end

   task automatic tick();
      @(negedge bclk);
      #(CLK_PERIOD/4);
   endtask

   // driver: one word per seven bit clocks, decoy at the other edge
   task automatic burst(input int n, input bit rise, input bit nar, input string tag);
      logic [W-1:0] w;
      rise_sel = rise;
      narrow = nar;
      exp_q.delete();
      armed = 0;
      matched = 0;
      for (int i = 0; i < n; i++) begin
         w = W'($urandom());
         @(negedge bclk);
         pclk = rise ? 1'b1 : 1'b0;
         pdata = w;
         exp_q.push_back(nar ? (w & MASK21) : w);
         repeat (rise ? 4 : 3) @(negedge bclk);
         pclk = rise ? 1'b0 : 1'b1;
         pdata = ~w;
         repeat (rise ? 2 : 3) @(negedge bclk);
      end
      repeat (30) @(negedge bclk);
      chk(armed && exp_q.size() == 0, tag, 32'(exp_q.size()), 0);
      chk(matched >= n - 1, tag, 32'(matched), 32'(n - 1));
   endtask

   task automatic count_settle(input string tag);
      int n = 0;
      bit early = 0;
      while (!ready && n < SETTLE + 10) begin
         if (fclk_oe || lane_oe != '0) early = 1;
         tick();
         n++;
      end
      chk(n == SETTLE, tag, 32'(n), 32'(SETTLE));
      chk(!early, tag, 32'(early), 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      int rises;
      bit pf;
      for (int l = 0; l < LANES; l++) sh[l] = '0;
      repeat (3) tick();
      // R1 reset state
      chk(lane_o == '0 && lane_oe == '0, "R1 lanes", {24'd0, lane_oe, lane_o}, 0);
      chk(!fclk_o && !fclk_oe && !ready, "R1 clk/ready", {fclk_o, fclk_oe, ready}, 0);

      @(negedge bclk);
      rst_n = 1'b1;
      #(CLK_PERIOD/4);
      // R2 settle interval
      count_settle("R2 settle");
      chk(lane_oe == 4'hF && fclk_oe, "R1 R2 enables", {27'd0, fclk_oe, lane_oe}, 5'h1F);

      // R6 and R5 on rising capture, wide mode
      burst(40, 1'b1, 1'b0, "R6 R7 rising");

      // R9 stalled pixel clock: framing clock keeps toggling
      rises = 0;
      pf = fclk_o;
      for (int i = 0; i < 42; i++) begin
         tick();
         if (fclk_o && !pf) rises++;
         pf = fclk_o;
      end
      chk(rises == 6, "R4 R9 free-run", 32'(rises), 6);

      // R7 falling capture
      burst(40, 1'b0, 1'b0, "R7 falling");

      // R8 narrow mode
      narrow_bad = 0;
      burst(30, 1'b1, 1'b1, "R8 narrow");
      chk(narrow_bad == 0, "R8 idle lane", 32'(narrow_bad), 0);
      chk(lane_oe == 4'h7, "R8 enables", {28'd0, lane_oe}, 4'h7);
      narrow = 1'b0;

      // R3 power-down
      @(negedge bclk);
      pd_n = 1'b0;
      #(CLK_PERIOD/4);
      chk(lane_oe == '0 && lane_o == '0 && !fclk_oe && !fclk_o, "R3 immediate",
          {26'd0, fclk_oe, fclk_o, lane_oe}, 0);
      tick();
      chk(!ready, "R3 ready drop", 32'(ready), 0);
      for (int i = 0; i < 10; i++) begin
         pclk = ~pclk;
         pdata = ~pdata;
         tick();
      end
      chk(lane_oe == '0 && lane_o == '0 && !fclk_oe && !fclk_o && !ready, "R3 held",
          {25'd0, ready, fclk_oe, fclk_o, lane_oe}, 0);
      pclk = 1'b0;
      @(negedge bclk);
      pd_n = 1'b1;
      #(CLK_PERIOD/4);
      count_settle("R3 resettle");

      burst(12, 1'b1, 1'b0, "R6 after power-up");

      finish_run();
   end

endmodule